// File: doc/BRIEF.md
# Programmable Async Character Transmitter

This block turns bytes into asynchronous serial characters. Bytes arrive on a valid/ready stream. They wait either in a 16-entry buffer or in a single holding slot, depending on a mode pin. A frame shifter then sends each byte as one character:

- a low start bit;
- 5 to 8 data bits, least significant bit first;
- an optional parity bit, which can be even, odd or forced to a fixed value;
- one, one-and-a-half or two stop bits.

Bit timing comes from a single-cycle tick at sixteen times the bit rate, supplied by an external divider. A break pin holds the line low. It does not disturb the character in flight.

The frame format is taken from the control pins when a byte moves from the buffer into the shifter. It then holds for the whole of that character. Two status flags are provided. The first reports that the buffer or holding slot is empty. The second reports that the buffer and the shifter are both empty, so the line is fully idle.

Back-pressure rules on the byte stream:

- A byte is taken on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` depends only on buffer occupancy and on `fifo_mode`. It never depends on `in_valid`.
- A source seeing `in_ready` low keeps its byte and retries.
- The mode pin should only change while `tx_idle` is high.

Top module: `tx_char_serializer`

## Requirements
- R1: After the start bit, exactly N data bits are sent, least significant bit first. N is 5, 6, 7 or 8, selected by `wlen` = 0, 1, 2 or 3.
- R2: With `two_stop` = 0 the stop interval is 16 ticks. With `two_stop` = 1 it is 24 ticks for 5-bit words and 32 ticks for 6, 7 and 8-bit words. The line is high during the stop interval.
- R3: With `par_on` = 1 and `par_stick` = 0, a parity bit follows the data. With `par_even` = 1, the count of ones in data plus parity is even. With `par_even` = 0, that count is odd. With `par_on` = 0, no parity bit is sent.
- R4: With `par_on` = 1 and `par_stick` = 1, the parity bit is 1 when `par_even` = 0 and 0 when `par_even` = 1.
- R5: `hold_empty` is 1 exactly when the buffer (or holding slot) holds no byte. A byte is moved into the shifter one clock after the shifter is found idle with the buffer non-empty.
- R6: `tx_idle` is 1 only when the buffer is empty and no character is being shifted.
- R7: The start, data and parity bits each last 16 ticks of `tick16`. The line only changes at a tick, or when a new character starts.
- R8: During and right after reset, `txd` = 1, `hold_empty` = 1 and `tx_idle` = 1. Together the two flags make a status value of 0x60: bit 5 is `hold_empty` and bit 6 is `tx_idle`.
- R9: While `brk` = 1, `txd` is 0. Framing carries on unchanged underneath.
- R10: `in_ready` is 1 when occupancy is below capacity. Capacity is 16 with `fifo_mode` = 1 and 1 with `fifo_mode` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| fifo_mode | input | 1 | 1: 16-entry buffer, 0: single holding slot |
| wlen | input | 2 | Data bits minus 5 |
| two_stop | input | 1 | Longer stop interval |
| par_on | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity, or forced 0 when par_stick is 1 |
| par_stick | input | 1 | Forced parity |
| brk | input | 1 | Hold line low |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be taken |
| in_data | input | 8 | Byte to send |
| txd | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Buffer empty |
| tx_idle | output | 1 | Buffer and shifter both empty |

## Verification
The assertions check on every cycle that:
- break always pulls the line low;
- the idle flag never claims idle while bytes are waiting;
- an accepted byte clears the empty flag;
- the single-slot mode never offers room for a second byte;
- the shifter's bit stays put between ticks.

Only the bench scenarios can show that a whole character is correct for each format. That covers the exact bit order, the parity values, the 24- and 32-tick stop intervals, and back-pressure across a burst larger than the buffer. The bench shows this by comparing the line and both flags every cycle against a behavioural frame model.

// File: rtl/tx_char_pkg.sv
package tx_char_pkg;
  localparam int CHAR_W = 8;
  localparam int SUB_W  = 5;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_DATA, PH_PARITY, PH_STOP
  } tx_phase_e;

  function automatic logic [3:0] data_bits(input logic [1:0] wl);
    return {2'b00, wl} + 4'd5;
  endfunction

  // last tick index of the stop interval
  function automatic logic [SUB_W-1:0] stop_last(input logic [1:0] wl, input logic ts);
    if (!ts)           return 5'd15;
    else if (wl == 2'd0) return 5'd23;
    else               return 5'd31;
  endfunction
endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
  parameter int DEPTH = 16,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         deep_mode,
  input  logic         push_valid,
  output logic         push_ready,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         is_empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count, cap;
  logic          do_push, do_pop;

  assign cap        = deep_mode ? CW'(DEPTH) : CW'(1);
  assign push_ready = count < cap;
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop && (count != '0);
  assign head       = mem[rd_ptr];
  assign is_empty   = (count == '0);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/tx_parity_gen.sv
module tx_parity_gen #(
  parameter int W = 8
) (
  input  logic [W-1:0] data,
  input  logic [3:0]   nbits,
  input  logic         par_even,
  input  logic         par_stick,
  output logic         pbit
);
  logic [W-1:0] used;
  logic         odd_ones;

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign used[i] = data[i] & (4'(i) < nbits);
  end

  assign odd_ones = ^used;

  always_comb begin
    if (par_stick)     pbit = ~par_even;
    else if (par_even) pbit = odd_ones;
    else               pbit = ~odd_ones;
  end
endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter
  import tx_char_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              avail,
  input  logic [CHAR_W-1:0] head,
  input  logic [1:0]        wlen,
  input  logic              two_stop,
  input  logic              par_on,
  input  logic              par_even,
  input  logic              par_stick,
  output logic              pop,
  output logic              ser_bit,
  output logic              busy,
  output tx_phase_e         phase
);
  logic [CHAR_W-1:0] sh_q;
  logic [1:0]        wlen_q;
  logic              two_stop_q, par_on_q, pbit_q, pbit_new;
  logic [SUB_W-1:0]  sub_q, last;
  logic [3:0]        bitn_q, nbits_q;

  tx_parity_gen #(.W(CHAR_W)) par_i (
    .data(head), .nbits(data_bits(wlen)), .par_even(par_even),
    .par_stick(par_stick), .pbit(pbit_new)
  );

  assign nbits_q = data_bits(wlen_q);
  assign last    = (phase == PH_STOP) ? stop_last(wlen_q, two_stop_q) : 5'd15;
  assign pop     = (phase == PH_IDLE) && avail;
  assign busy    = (phase != PH_IDLE);

  always_comb begin
    case (phase)
      PH_START:  ser_bit = 1'b0;
      PH_DATA:   ser_bit = sh_q[0];
      PH_PARITY: ser_bit = pbit_q;
      default:   ser_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      sh_q       <= '0;
      wlen_q     <= '0;
      two_stop_q <= 1'b0;
      par_on_q   <= 1'b0;
      pbit_q     <= 1'b0;
      sub_q      <= '0;
      bitn_q     <= '0;
    end else if (phase == PH_IDLE) begin
      if (avail) begin
        sh_q       <= head;
        wlen_q     <= wlen;
        two_stop_q <= two_stop;
        par_on_q   <= par_on;
        pbit_q     <= pbit_new;
        sub_q      <= '0;
        phase      <= PH_START;
      end
    end else if (tick) begin
      if (sub_q != last) begin
        sub_q <= sub_q + 1'b1;
      end else begin
        sub_q <= '0;
        case (phase)
          PH_START: begin
            phase  <= PH_DATA;
            bitn_q <= '0;
          end
          PH_DATA: begin
            if (bitn_q == nbits_q - 4'd1) begin
              phase <= par_on_q ? PH_PARITY : PH_STOP;
            end else begin
              bitn_q <= bitn_q + 4'd1;
              sh_q   <= sh_q >> 1;
            end
          end
          PH_PARITY: phase <= PH_STOP;
          default:   phase <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tx_char_serializer.sv
module tx_char_serializer
  import tx_char_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              fifo_mode,
  input  logic [1:0]        wlen,
  input  logic              two_stop,
  input  logic              par_on,
  input  logic              par_even,
  input  logic              par_stick,
  input  logic              brk,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_data,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_idle
);
  logic [CHAR_W-1:0] head;
  logic              buf_empty, pop, ser_bit, busy;
  tx_phase_e         cur_phase;

  tx_hold_buf #(.DEPTH(DEPTH), .W(CHAR_W)) buf_i (
    .clk(clk), .rst_n(rst_n), .deep_mode(fifo_mode),
    .push_valid(in_valid), .push_ready(in_ready), .push_data(in_data),
    .pop(pop), .head(head), .is_empty(buf_empty)
  );

  tx_frame_shifter shf_i (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .avail(!buf_empty),
    .head(head), .wlen(wlen), .two_stop(two_stop), .par_on(par_on),
    .par_even(par_even), .par_stick(par_stick), .pop(pop),
    .ser_bit(ser_bit), .busy(busy), .phase(cur_phase)
  );

  assign txd        = brk ? 1'b0 : ser_bit;
  assign hold_empty = buf_empty;
  assign tx_idle    = buf_empty && !busy;
endmodule

// File: rtl/tx_char_serializer_chk.sv
module tx_char_serializer_chk
  import tx_char_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      tick16,
  input logic      brk,
  input logic      txd,
  input logic      fifo_mode,
  input logic      in_valid,
  input logic      in_ready,
  input logic      hold_empty,
  input logic      tx_idle,
  input logic      ser_bit,
  input tx_phase_e phase
);
  // R9
  break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !txd);
  // R6
  idle_implies_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> hold_empty);
  // R5
  push_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !hold_empty);
  // R10
  single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && !hold_empty) |-> !in_ready);
  // R7
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick16 && phase != PH_IDLE) |=> $stable(ser_bit));
endmodule

bind tx_char_serializer tx_char_serializer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .brk(brk), .txd(txd),
  .fifo_mode(fifo_mode), .in_valid(in_valid), .in_ready(in_ready),
  .hold_empty(hold_empty), .tx_idle(tx_idle), .ser_bit(ser_bit),
  .phase(cur_phase)
);

// File: tb/tx_char_serializer_tb_top.sv
`timescale 1ns/1ps
module tx_char_serializer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, fifo_mode = 1'b1;
  logic [1:0] wlen = 2'd3;
  logic two_stop = 1'b0, par_on = 1'b0, par_even = 1'b0, par_stick = 1'b0, brk = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_data = 8'h00;
  logic txd, hold_empty, tx_idle;

  int total = 0, bad = 0, cycles = 0, tick_div = 1, tick_cnt = 0;
  bit checking = 0, pushed_flag = 0, done = 0;

  // behavioural model state
  logic [7:0] q[$];
  int m_st = 0, m_sub = 0, m_bitn = 0, m_nbits = 8, m_stopt = 16;
  bit m_paron = 0, m_pbit = 0;
  logic [7:0] m_sh = 0;

  tx_char_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .fifo_mode(fifo_mode),
    .wlen(wlen), .two_stop(two_stop), .par_on(par_on), .par_even(par_even),
    .par_stick(par_stick), .brk(brk), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .txd(txd), .hold_empty(hold_empty), .tx_idle(tx_idle)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tick16 <= (tick_cnt == 0);
    tick_cnt <= (tick_cnt + 1 >= tick_div) ? 0 : tick_cnt + 1;
  end

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int cap, ones;
    bit do_push, do_pop;
    if (!rst_n) begin
      q.delete(); m_st = 0; m_sub = 0; pushed_flag = 0;
    end else begin
      cap = fifo_mode ? 16 : 1;
      do_push = in_valid && (q.size() < cap);
      do_pop = (m_st == 0) && (q.size() > 0);
      pushed_flag = do_push;
      if (m_st != 0 && tick16) begin
        if (m_sub != ((m_st == 4) ? m_stopt - 1 : 15)) m_sub++;
        else begin
          m_sub = 0;
          case (m_st)
            1: begin m_st = 2; m_bitn = 0; end
            2: if (m_bitn == m_nbits - 1) m_st = m_paron ? 3 : 4;
               else begin m_bitn++; m_sh = m_sh >> 1; end
            3: m_st = 4;
            default: m_st = 0;
          endcase
        end
      end
      if (do_pop) begin
        m_sh = q[0];
        m_nbits = 5 + int'(wlen);
        m_stopt = !two_stop ? 16 : (m_nbits == 5 ? 24 : 32);
        m_paron = par_on;
        ones = 0;
        for (int i = 0; i < m_nbits; i++) ones += int'(m_sh[i]);
        if (par_stick) m_pbit = !par_even;
        else if (par_even) m_pbit = ones[0];
        else m_pbit = !ones[0];
        m_st = 1; m_sub = 0;
        void'(q.pop_front());
      end
      if (do_push) q.push_back(in_data);
    end
  end

  always @(posedge clk) begin
    logic exp_txd;
    string tag;
    #1;
    if (rst_n && checking && !done) begin
      case (m_st)
        1: begin exp_txd = 1'b0; tag = "R7"; end
        2: begin exp_txd = m_sh[0]; tag = "R1"; end
        3: begin exp_txd = m_pbit; tag = par_stick ? "R4" : "R3"; end
        default: begin exp_txd = 1'b1; tag = "R2"; end
      endcase
      if (brk) begin exp_txd = 1'b0; tag = "R9"; end
      check(tag, txd, exp_txd);
      check("R5", hold_empty, q.size() == 0);
      check("R6", tx_idle, (q.size() == 0) && (m_st == 0));
      check("R10", in_ready, q.size() < (fifo_mode ? 16 : 1));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_data = b;
    do @(negedge clk); while (!pushed_flag);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(m_st == 0 && q.size() == 0));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int n = 0;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8", txd, 1'b1);
    check("R8", hold_empty, 1'b1);
    check("R8", tx_idle, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", txd, 1'b1);
    check("R8", {1'b0, tx_idle, hold_empty, 5'b0} == 8'h60, 1'b1);
    checking = 1;
    // all formats, buffer mode
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 5; p++) begin
          @(negedge clk);
          wlen = 2'(w); two_stop = s[0];
          par_on = (p != 0); par_even = (p == 2 || p == 4); par_stick = (p >= 3);
          send(8'(n * 37 + 11)); n++;
          send(8'(n * 91 + 5)); n++;
          wait_idle();
        end
    // burst larger than the buffer: back-pressure (R10)
    wlen = 2'd3; two_stop = 1'b0; par_on = 1'b1; par_even = 1'b1; par_stick = 1'b0;
    for (int i = 0; i < 20; i++) send(8'(i * 53 + 7));
    wait_idle();
    // single holding slot, slower ticks
    fifo_mode = 1'b0; tick_div = 3;
    for (int i = 0; i < 3; i++) send(8'(i * 29 + 200));
    wait_idle();
    // break in the middle of a character (R9)
    fifo_mode = 1'b1; tick_div = 1;
    send(8'hA5);
    repeat (50) @(negedge clk);
    brk = 1'b1;
    repeat (40) @(negedge clk);
    brk = 1'b0;
    wait_idle();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule